// File: doc/BRIEF.md
# Raster timing generator with line prefetch

This block produces the horizontal and vertical timing of a raster display from a set of registers that software programs. A pixel counter runs across each line and a line counter runs down each frame. Comparators on the two counts drive the sync pulses, the display-enable window and a single-cycle prefetch strobe. The strobe tells the pixel fetch logic, which sits outside this block, to start loading the next line a programmable number of pixels before the current line ends.

Every timing register holds its value minus one. The total registers give the last pixel or line index. Each sync pulse covers the counts strictly after its start register, up to and including its end register. Software writes land in a staging copy. The counters use a live copy, which takes the staged values only at a frame boundary or while the generator is stopped, so a frame never mixes two timings.

A sync stage after the comparators applies the output options. Each sync pulse can have its polarity inverted. Each sync can be switched off on its own for power saving, or both can be switched off at once. A composite sync level can be produced for a sync-on-video output. A display-off bit blanks the video-enable output while the sync keeps running.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads as zero. Before any write, pix_x and line_y are 0, and hsync, vsync, de, video_on, prefetch and sync_tip are all 0.
- R2: Register map (cfg_addr): 0 control, 1 line total, 2 active width, 3 hsync start, 4 hsync end, 5 frame total, 6 active height, 7 vsync start, 8 vsync end, 9 prefetch position, 10 sync control, 11 display control. Control bit 0 is run. While run is 0, pix_x and line_y stay at 0 and the live timing copy follows the staged values.
- R3: While run is 1, pix_x counts from 0 to the line total and then returns to 0. line_y advances by one at each such wrap and returns to 0 after the frame total.
- R4: Timing writes made while run is 1 take effect only in the first cycle of the next frame.
- R5: de is 1 exactly when run is 1, control bit 1 (refresh) is 1, pix_x ≤ active width and line_y ≤ active height.
- R6: The raw hsync is active while start < pix_x ≤ end. The raw vsync is active on the lines where start < line_y ≤ end. Both raw syncs are inactive while run is 0.
- R7: prefetch is 1 for one cycle when run and refresh are set, pix_x equals the prefetch position, and the next line is active. The next line is active when line_y < active height or line_y equals the frame total.
- R8: Sync control bit 3 inverts hsync and bit 4 inverts vsync.
- R9: Sync control bit 5 holds hsync at its inactive level. Bit 6 does the same for vsync. Bit 1 does it for both and also forces sync_tip to 0.
- R10: When sync control bit 0 is set and bit 1 is clear, sync_tip equals the OR of the raw hsync and the raw vsync. Otherwise sync_tip is 0.
- R11: video_on is de gated by display control bit 1 (display off). hsync and vsync are unaffected by that bit.
- R12: Writes to addresses 12 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 16 | Write data |
| hsync | output | 1 | Horizontal sync after the polarity and disable options |
| vsync | output | 1 | Vertical sync after the polarity and disable options |
| sync_tip | output | 1 | Composite sync level for a sync-on-video output |
| de | output | 1 | Active display window |
| video_on | output | 1 | Display window after display-off blanking |
| prefetch | output | 1 | Next-line fetch strobe |
| pix_x | output | CW | Pixel counter |
| line_y | output | CW | Line counter |

## Verification
The assertions assume that software keeps each start register at or below the matching end register, and both within the total. They also assume that the active limits do not exceed the totals. Sweeps and timing writes outside those limits are not covered. The bench always stops the generator before it changes the sync or display options. It programs one small, self-consistent mode, a 10-pixel by 6-line frame, and makes a single timing change while the generator runs: a narrower active width. That change leaves every ordering assumption intact.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned POS_W  = 16;

  // register indices
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TBASE = 1;   // first timing register
  localparam int unsigned A_SYNC = 10;
  localparam int unsigned A_DISP = 11;

  // timing register slots relative to A_TBASE
  localparam int unsigned T_HTOT = 0;
  localparam int unsigned T_HACT = 1;
  localparam int unsigned T_HSB  = 2;
  localparam int unsigned T_HSE  = 3;
  localparam int unsigned T_VTOT = 4;
  localparam int unsigned T_VACT = 5;
  localparam int unsigned T_VSB  = 6;
  localparam int unsigned T_VSE  = 7;
  localparam int unsigned T_PF   = 8;
  localparam int unsigned T_NUM  = 9;

  typedef logic [POS_W-1:0] pos_t;

  // count lies in the pulse window (start, end]
  function automatic logic span_hit(pos_t pos, pos_t beg, pos_t fin);
    return (pos > beg) && (pos <= fin);
  endfunction

  // count lies inside the visible area [0, last]
  function automatic logic in_view(pos_t pos, pos_t last);
    return pos <= last;
  endfunction

  // the line after 'line' is a visible line
  function automatic logic next_visible(pos_t line, pos_t last, pos_t total);
    return (line < last) || (line == total);
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned NT = rtg_pkg::T_NUM
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [rtg_pkg::REG_AW-1:0] addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    load_slot,
  output logic                    run,
  output logic                    refresh,
  output logic                    s_rgb,
  output logic                    s_all_off,
  output logic                    s_hinv,
  output logic                    s_vinv,
  output logic                    s_hoff,
  output logic                    s_voff,
  output logic                    disp_off,
  output logic [NT-1:0][CW-1:0]   live
);
  import rtg_pkg::*;

  logic unused_hi;
  assign unused_hi = &{1'b0, wdata[DW-1:CW]};

  // control, sync and display words: applied on the next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; refresh <= 1'b0;
      s_rgb <= 1'b0; s_all_off <= 1'b0; s_hinv <= 1'b0;
      s_vinv <= 1'b0; s_hoff <= 1'b0; s_voff <= 1'b0;
      disp_off <= 1'b0;
    end else if (we) begin
      case (addr)
        REG_AW'(A_CTRL): begin
          run     <= wdata[0];
          refresh <= wdata[1];
        end
        REG_AW'(A_SYNC): begin
          s_rgb     <= wdata[0];
          s_all_off <= wdata[1];
          s_hinv    <= wdata[3];
          s_vinv    <= wdata[4];
          s_hoff    <= wdata[5];
          s_voff    <= wdata[6];
        end
        REG_AW'(A_DISP): disp_off <= wdata[1];
        default: ;
      endcase
    end
  end

  // timing words: staged on write, copied to live at a frame slot
  for (genvar i = 0; i < NT; i++) begin : g_tim
    logic [CW-1:0] stg;
    logic [CW-1:0] cur;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg <= '0;
        cur <= '0;
      end else begin
        if (we && addr == REG_AW'(A_TBASE + i)) stg <= wdata[CW-1:0];
        if (load_slot) cur <= stg;
      end
    end
    assign live[i] = cur;
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] pix,
  output logic [CW-1:0] line,
  output logic          line_end,
  output logic          frame_end
);
  assign line_end  = (pix == htot);
  assign frame_end = line_end && (line == vtot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else if (!run) begin
      pix  <= '0;
      line <= '0;
    end else if (line_end) begin
      pix  <= '0;
      line <= frame_end ? '0 : line + CW'(1);
    end else begin
      pix <= pix + CW'(1);
    end
  end
endmodule

// File: rtl/rtg_sync.sv
module rtg_sync #(
  parameter int unsigned CW = 12
) (
  input  logic          run,
  input  logic          refresh,
  input  logic [CW-1:0] pix,
  input  logic [CW-1:0] line,
  input  logic [CW-1:0] vtot,
  input  logic [CW-1:0] hact,
  input  logic [CW-1:0] vact,
  input  logic [CW-1:0] hsb,
  input  logic [CW-1:0] hse,
  input  logic [CW-1:0] vsb,
  input  logic [CW-1:0] vse,
  input  logic [CW-1:0] pf,
  input  logic          s_rgb,
  input  logic          s_all_off,
  input  logic          s_hinv,
  input  logic          s_vinv,
  input  logic          s_hoff,
  input  logic          s_voff,
  input  logic          disp_off,
  output logic          hs_raw,
  output logic          vs_raw,
  output logic          de,
  output logic          video_on,
  output logic          prefetch,
  output logic          hsync,
  output logic          vsync,
  output logic          sync_tip
);
  import rtg_pkg::*;

  pos_t px, ln;
  assign px = pos_t'(pix);
  assign ln = pos_t'(line);

  logic showing;
  assign showing = run && refresh;

  assign hs_raw = run && span_hit(px, pos_t'(hsb), pos_t'(hse));
  assign vs_raw = run && span_hit(ln, pos_t'(vsb), pos_t'(vse));

  assign de = showing && in_view(px, pos_t'(hact)) && in_view(ln, pos_t'(vact));
  assign video_on = de && !disp_off;

  assign prefetch = showing && (px == pos_t'(pf))
                    && next_visible(ln, pos_t'(vact), pos_t'(vtot));

  logic h_mute, v_mute;
  assign h_mute = s_hoff || s_all_off;
  assign v_mute = s_voff || s_all_off;

  assign hsync    = h_mute ? s_hinv : (hs_raw ^ s_hinv);
  assign vsync    = v_mute ? s_vinv : (vs_raw ^ s_vinv);
  assign sync_tip = s_rgb && !s_all_off && (hs_raw || vs_raw);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int unsigned CW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          sync_tip,
  output logic          de,
  output logic          video_on,
  output logic          prefetch,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);
  import rtg_pkg::*;

  localparam int unsigned NT = T_NUM;

  logic run, refresh, disp_off;
  logic s_rgb, s_all_off, s_hinv, s_vinv, s_hoff, s_voff;
  logic [NT-1:0][CW-1:0] live;
  logic line_end, frame_end, load_slot;
  logic hs_raw, vs_raw;

  logic [CW-1:0] htot, hact, hsb, hse, vtot, vact, vsb, vse, pf;
  assign htot = live[T_HTOT];
  assign hact = live[T_HACT];
  assign hsb  = live[T_HSB];
  assign hse  = live[T_HSE];
  assign vtot = live[T_VTOT];
  assign vact = live[T_VACT];
  assign vsb  = live[T_VSB];
  assign vse  = live[T_VSE];
  assign pf   = live[T_PF];

  // live copy follows staging while stopped, else only at frame wrap
  assign load_slot = !run || frame_end;

  rtg_regs #(.CW(CW), .DW(DW), .NT(NT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load_slot(load_slot), .run(run), .refresh(refresh),
    .s_rgb(s_rgb), .s_all_off(s_all_off), .s_hinv(s_hinv), .s_vinv(s_vinv),
    .s_hoff(s_hoff), .s_voff(s_voff), .disp_off(disp_off), .live(live)
  );

  rtg_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .htot(htot), .vtot(vtot),
    .pix(pix_x), .line(line_y), .line_end(line_end), .frame_end(frame_end)
  );

  rtg_sync #(.CW(CW)) u_sync (
    .run(run), .refresh(refresh), .pix(pix_x), .line(line_y), .vtot(vtot),
    .hact(hact), .vact(vact), .hsb(hsb), .hse(hse), .vsb(vsb), .vse(vse),
    .pf(pf), .s_rgb(s_rgb), .s_all_off(s_all_off), .s_hinv(s_hinv),
    .s_vinv(s_vinv), .s_hoff(s_hoff), .s_voff(s_voff), .disp_off(disp_off),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .de(de), .video_on(video_on),
    .prefetch(prefetch), .hsync(hsync), .vsync(vsync), .sync_tip(sync_tip)
  );
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          refresh,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] line_y,
  input logic [CW-1:0] htot,
  input logic [CW-1:0] vtot,
  input logic [CW-1:0] hact,
  input logic [CW-1:0] vact,
  input logic          de,
  input logic          video_on,
  input logic          prefetch,
  input logic          hsync,
  input logic          s_hinv,
  input logic          s_hoff,
  input logic          s_all_off
);
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_x == '0 && line_y == '0));

  p_pixel_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_x != htot) |=> pix_x == CW'($past(pix_x) + CW'(1)));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_x == htot && line_y == vtot) |=> (pix_x == '0 && line_y == '0));

  p_midframe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(pix_x == htot && line_y == vtot)) |=> ($stable(hact) && $stable(htot) && $stable(vtot)));

  p_de_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (refresh && pix_x <= hact && line_y <= vact));

  p_prefetch_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch && pix_x != htot) |=> !prefetch);

  p_hsync_muted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hoff || s_all_off) |-> hsync == s_hinv);

  p_video_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> de);
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .refresh(refresh),
  .pix_x(pix_x), .line_y(line_y), .htot(htot), .vtot(vtot),
  .hact(hact), .vact(vact), .de(de), .video_on(video_on),
  .prefetch(prefetch), .hsync(hsync), .s_hinv(s_hinv),
  .s_hoff(s_hoff), .s_all_off(s_all_off)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  localparam int CW = 12;
  localparam int HT = 9, HA = 5, HSB = 6, HSE = 7;
  localparam int VT = 5, VA = 2, VSB = 3, VSE = 4, PF = 7;
  localparam int FRAME = (HT + 1) * (VT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic hsync, vsync, sync_tip, de, video_on, prefetch;
  logic [CW-1:0] pix_x, line_y;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int ex, ey, m_ha, pend_ha;
  bit rn, rf, has_pend;

  always #2 clk = ~clk;

  raster_timing_gen #(.CW(CW), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hsync(hsync), .vsync(vsync), .sync_tip(sync_tip),
    .de(de), .video_on(video_on), .prefetch(prefetch),
    .pix_x(pix_x), .line_y(line_y)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_now(input logic [15:0] sc, input logic [15:0] dc, input string tag);
    bit e_de, e_hr, e_vr, e_pf, e_h, e_v, e_tip, e_vid;
    e_de = rn && rf && (ex < m_ha + 1) && (ey < VA + 1);
    e_hr = rn && (ex >= HSB + 1) && (ex <= HSE);
    e_vr = rn && (ey >= VSB + 1) && (ey <= VSE);
    e_pf = rn && rf && (ex == PF) && ((ey + 1 <= VA) || (ey == VT));
    e_h  = (sc[5] || sc[1]) ? sc[3] : (e_hr != sc[3]);
    e_v  = (sc[6] || sc[1]) ? sc[4] : (e_vr != sc[4]);
    e_tip = sc[0] && !sc[1] && (e_hr || e_vr);
    e_vid = e_de && !dc[1];
    chk(int'(pix_x) == ex, {"R3 pix ", tag}, int'(pix_x), ex);
    chk(int'(line_y) == ey, {"R3 line ", tag}, int'(line_y), ey);
    chk(de == e_de, {"R5 de ", tag}, int'(de), int'(e_de));
    chk(prefetch == e_pf, {"R7 prefetch ", tag}, int'(prefetch), int'(e_pf));
    chk(hsync == e_h, {"hsync ", tag}, int'(hsync), int'(e_h));
    chk(vsync == e_v, {"vsync ", tag}, int'(vsync), int'(e_v));
    chk(sync_tip == e_tip, {"sync_tip ", tag}, int'(sync_tip), int'(e_tip));
    chk(video_on == e_vid, {"video_on ", tag}, int'(video_on), int'(e_vid));
  endtask

  task automatic run_cfg(input logic [15:0] ctl, input logic [15:0] sc,
                         input logic [15:0] dc, input int frames,
                         input string tag, input bit mid_change);
    wr(0, 0);
    wr(10, int'(sc));
    wr(11, int'(dc));
    wr(2, HA);
    m_ha = HA; has_pend = 1'b0;
    wr(0, int'(ctl));
    rn = ctl[0]; rf = ctl[1]; ex = 0; ey = 0;
    for (int c = 0; c < frames * FRAME; c++) begin
      check_now(sc, dc, tag);
      if (mid_change && c == 13) begin
        cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 16'd2;
        pend_ha = 2; has_pend = 1'b1;
      end else begin
        cfg_we = 1'b0;
      end
      if (rn) begin
        if (ex == HT) begin
          ex = 0;
          if (ey == VT) begin
            ey = 0;
            if (has_pend) begin m_ha = pend_ha; has_pend = 1'b0; end
          end else ey++;
        end else ex++;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pix_x == '0 && line_y == '0, "R1 counters", int'(pix_x), 0);
    chk({hsync, vsync, de, video_on, prefetch, sync_tip} == 6'b0, "R1 outputs",
        int'({hsync, vsync, de, video_on, prefetch, sync_tip}), 0);

    // program the small mode while stopped
    wr(1, HT); wr(2, HA); wr(3, HSB); wr(4, HSE);
    wr(5, VT); wr(6, VA); wr(7, VSB); wr(8, VSE); wr(9, PF);

    // R12: unmapped writes must not start or reconfigure anything
    for (int a = 12; a < 16; a++) wr(a, 16'hFFFF);
    @(negedge clk);
    chk(pix_x == '0, "R12 pix after unmapped write", int'(pix_x), 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R12 sync after unmapped write",
        int'({hsync, vsync}), 0);
    m_ha = HA;
    run_cfg(16'h0003, 16'h0000, 16'h0000, 1, "R12", 1'b0);

    run_cfg(16'h0000, 16'h0000, 16'h0000, 1, "R2 stopped", 1'b0);
    run_cfg(16'h0003, 16'h0000, 16'h0000, 2, "R6 base", 1'b0);
    run_cfg(16'h0003, 16'h0000, 16'h0000, 2, "R4 midframe", 1'b1);
    run_cfg(16'h0001, 16'h0000, 16'h0000, 1, "R5 no refresh", 1'b0);
    run_cfg(16'h0003, 16'h0008, 16'h0000, 1, "R8 hinv", 1'b0);
    run_cfg(16'h0003, 16'h0010, 16'h0000, 1, "R8 vinv", 1'b0);
    run_cfg(16'h0003, 16'h0018, 16'h0000, 1, "R8 both", 1'b0);
    run_cfg(16'h0003, 16'h0020, 16'h0000, 1, "R9 hoff", 1'b0);
    run_cfg(16'h0003, 16'h0048, 16'h0000, 1, "R9 voff", 1'b0);
    run_cfg(16'h0003, 16'h001B, 16'h0000, 1, "R9 alloff", 1'b0);
    run_cfg(16'h0003, 16'h0001, 16'h0000, 1, "R10 rgb", 1'b0);
    run_cfg(16'h0003, 16'h0021, 16'h0000, 1, "R10 rgb hoff", 1'b0);
    run_cfg(16'h0003, 16'h0000, 16'h0002, 1, "R11 dispoff", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule